// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block is the digital core of a buck controller with two, three or four phases. A master oscillator delivers a one-cycle tick. Each phase output is a logic-level on-time request to an external gate driver. After enable, the sequencer spends a short startup window reading strap inputs. These inputs report which optional phase pins are tied to ground, and a grounded phase is switched off for the whole run.

Once the window closes, each master tick starts exactly one active phase. Phases are started in ascending order, with wrap-around. Every phase output stays high until that phase's own termination request arrives, so on-times of different phases can overlap and a phase can stay on for almost its whole period. If a phase is still on when its next turn comes, it is pulled low for one clock and then restarted. This gives it a guaranteed minimum off-time.

Dropping enable clears every output. It also returns the start pointer to phase 1 and re-arms strap detection for the next enable.

Top module: `mps_sequencer`

## Requirements
- R1: While `en` is low, every `pwm` bit is low from the next clock on. After `en` rises again, the first phase to start is phase 1 (bit 0), and strap detection runs again.
- R2: The first two master ticks after `en` rises form the detection window. All outputs stay low during that window, and `strap_gnd` is sampled at the second tick.
- R3: `strap_gnd` bit 0 reports the phase-3 pin (pwm bit 2) as grounded, and bit 1 reports the phase-4 pin (pwm bit 3). With no bit set, four phases run. With only bit 1 set, phases 1 to 3 run. With both bits set, phases 1 and 2 run. With only bit 0 set, phases 1, 2 and 4 run.
- R4: A phase found grounded stays low for the whole run, and its `term` input has no effect on it.
- R5: After the window, each tick starts one phase. Phases start in ascending order, wrap to phase 1 and skip disabled phases. The first start is phase 1.
- R6: Each active phase starts once every N ticks, where N is the number of active phases.
- R7: A start on a phase whose output is low drives that output high on the clock edge that samples the tick.
- R8: A `term` bit that is high while its output is high, with no start on that phase, drives the output low on the next clock. A `term` on a low output has no effect.
- R9: A start on a phase whose output is still high drives it low for exactly one clock. The output then goes high again.
- R10: Outputs are independent of one another, so two or more can be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable |
| tick | input | 1 | Master oscillator tick, one clock wide |
| strap_gnd | input | NPH-MIN_PH | Grounded flags for the optional phases, lowest optional phase at bit 0 |
| term | input | NPH | Per-phase on-time termination request |
| pwm | output | NPH | Per-phase logic-level output |

## Verification
The bench builds the block with its defaults: four phases, two of them optional, and a two-tick detection window. Every strap combination is therefore swept, covering all three phase counts and the gapped order 1, 2, 4. Each combination runs with a tick on every clock and with a tick every third clock. The one-tick-per-clock pace puts a restart's forced low cycle right next to a neighbouring phase's start, and it makes overlapping on-times certain. Re-enabling between combinations exercises the pointer reset and the renewed strap sampling.

// File: rtl/mps_pkg.sv
package mps_pkg;

    // Progress of the startup strap detection
    typedef enum logic [1:0] {
        MODE_ARMED  = 2'd0,
        MODE_DETECT = 2'd1,
        MODE_RUN    = 2'd2
    } mode_e;

    // State of one phase output cell
    typedef struct packed {
        logic drive;    // output level
        logic recover;  // forced off-cycle in progress, restart next clock
    } leg_t;

endpackage

// File: rtl/mps_detect.sv
module mps_detect
    import mps_pkg::*;
#(
    parameter int NPH       = 4,
    parameter int MIN_PH    = 2,
    parameter int DET_TICKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  tick,
    input  logic [NPH-MIN_PH-1:0] strap_gnd,
    output logic                  run,
    output logic [NPH-1:0]        act_mask
);

    localparam int CW = (DET_TICKS < 2) ? 1 : $clog2(DET_TICKS + 1);

    typedef struct packed {
        mode_e          mode;
        logic [CW-1:0]  cnt;
        logic [NPH-1:0] mask;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (!en) begin
            det_d.mode = MODE_ARMED;
            det_d.cnt  = '0;
            det_d.mask = '1;
        end else if (det_q.mode != MODE_RUN && tick) begin
            det_d.mode = MODE_DETECT;
            if (det_q.cnt == CW'(DET_TICKS - 1)) begin
                // last window tick: latch which optional phases survive
                det_d.mode = MODE_RUN;
                det_d.cnt  = '0;
                det_d.mask = {~strap_gnd, {MIN_PH{1'b1}}};
            end else begin
                det_d.cnt = det_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.mode <= MODE_ARMED;
            det_q.cnt  <= '0;
            det_q.mask <= '1;
        end else begin
            det_q <= det_d;
        end
    end

    assign run      = (det_q.mode == MODE_RUN);
    assign act_mask = det_q.mask;

endmodule

// File: rtl/mps_ring.sv
module mps_ring #(
    parameter int NPH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           run,
    input  logic           tick,
    input  logic [NPH-1:0] act_mask,
    output logic [NPH-1:0] start
);

    localparam int PW = (NPH < 2) ? 1 : $clog2(NPH);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } ring_t;

    ring_t         ring_d, ring_q;
    logic [PW-1:0] nxt;

    // nearest enabled phase after the current one; farthest candidate first
    always_comb begin
        nxt = ring_q.ptr;
        for (int k = NPH - 1; k >= 1; k--) begin
            if (act_mask[(int'(ring_q.ptr) + k) % NPH]) begin
                nxt = PW'((int'(ring_q.ptr) + k) % NPH);
            end
        end
    end

    always_comb begin
        ring_d = ring_q;
        start  = '0;
        if (!en) begin
            ring_d.ptr = '0;
        end else if (run && tick) begin
            start[ring_q.ptr] = 1'b1;
            ring_d.ptr        = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q.ptr <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

endmodule

// File: rtl/mps_leg.sv
module mps_leg
    import mps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic start,
    input  logic term,
    output logic drive
);

    leg_t leg_d, leg_q;

    always_comb begin
        leg_d = leg_q;
        if (!act) begin
            leg_d = '0;
        end else if (leg_q.recover) begin
            leg_d.drive   = 1'b1;
            leg_d.recover = 1'b0;
        end else if (start) begin
            if (leg_q.drive) begin
                leg_d.drive   = 1'b0;
                leg_d.recover = 1'b1;
            end else begin
                leg_d.drive = 1'b1;
            end
        end else if (term && leg_q.drive) begin
            leg_d.drive = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leg_q <= '0;
        end else begin
            leg_q <= leg_d;
        end
    end

    assign drive = leg_q.drive;

endmodule

// File: rtl/mps_sequencer.sv
module mps_sequencer #(
    parameter int NPH       = 4,
    parameter int MIN_PH    = 2,
    parameter int DET_TICKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  tick,
    input  logic [NPH-MIN_PH-1:0] strap_gnd,
    input  logic [NPH-1:0]        term,
    output logic [NPH-1:0]        pwm
);

    logic           run;
    logic [NPH-1:0] act_mask;
    logic [NPH-1:0] start;

    mps_detect #(
        .NPH       (NPH),
        .MIN_PH    (MIN_PH),
        .DET_TICKS (DET_TICKS)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .strap_gnd (strap_gnd),
        .run       (run),
        .act_mask  (act_mask)
    );

    mps_ring #(
        .NPH (NPH)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .run      (run),
        .tick     (tick),
        .act_mask (act_mask),
        .start    (start)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        mps_leg u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (en && run && act_mask[g]),
            .start (start[g]),
            .term  (term[g]),
            .drive (pwm[g])
        );
    end

endmodule

// File: rtl/mps_sequencer_chk.sv
module mps_sequencer_chk #(
    parameter int NPH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           run,
    input logic [NPH-1:0] act_mask,
    input logic [NPH-1:0] start,
    input logic [NPH-1:0] term,
    input logic [NPH-1:0] pwm
);

    // R1
    en_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pwm == '0));

    // R2
    window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm == '0));

    // R4
    grounded_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm & ~act_mask) == '0);

    // R5
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start) && ((start & ~act_mask) == '0));

    // R8
    term_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((term & pwm & ~start) != '0) |=> ((pwm & $past(term & pwm & ~start)) == '0));

    // R9
    restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((start & pwm) != '0) |=> ((pwm & $past(start & pwm)) == '0));

endmodule

bind mps_sequencer mps_sequencer_chk #(.NPH(NPH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .run      (run),
    .act_mask (act_mask),
    .start    (start),
    .term     (term),
    .pwm      (pwm)
);

// File: tb/sim_mps_sequencer.sv
`timescale 1ns/1ps
module sim_mps_sequencer;

    localparam int NPH    = 4;
    localparam int MIN_PH = 2;
    localparam int DET    = 2;
    localparam int NTICK  = 12;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  en = 1'b0;
    logic                  tick = 1'b0;
    logic [NPH-MIN_PH-1:0] strap = '0;
    logic [NPH-1:0]        term = '0;
    logic [NPH-1:0]        pwm;

    always #2.5 clk = ~clk;

    mps_sequencer #(.NPH(NPH), .MIN_PH(MIN_PH), .DET_TICKS(DET)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .strap_gnd (strap),
        .term      (term),
        .pwm       (pwm)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    bit             mon_on = 1'b0;
    int             highs [NPH];
    int             rises [NPH];
    int             order [16];
    int             n_order;
    int             max_on;
    logic [NPH-1:0] prev = '0;

    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            for (int i = 0; i < NPH; i++) begin
                if (pwm[i]) highs[i]++;
                if (pwm[i] && !prev[i]) begin
                    rises[i]++;
                    if (n_order < 16) begin
                        order[n_order] = i;
                        n_order++;
                    end
                end
            end
            if ($countones(pwm) > max_on) max_on = $countones(pwm);
        end
        prev = pwm;
    end

    task automatic clear_stats();
        for (int i = 0; i < NPH; i++) begin
            highs[i] = 0;
            rises[i] = 0;
        end
        n_order = 0;
        max_on  = 0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_ticks(input int n, input int p);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            for (int j = 1; j < p; j++) @(negedge clk);
        end
    endtask

    initial begin
        clear_stats();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm == '0, "R1", "outputs after reset", int'(pwm), 0);

        for (int p = 1; p <= 3; p += 2) begin
            for (int s = 0; s < 4; s++) begin
                logic [1:0]     sb;
                logic [NPH-1:0] mask;
                int             n;
                int             alist [NPH];
                int             total;
                sb   = 2'(s);
                mask = {~sb, 2'b11};
                n    = 0;
                for (int i = 0; i < NPH; i++) begin
                    if (mask[i]) begin
                        alist[n] = i;
                        n++;
                    end
                end

                en    = 1'b0;
                term  = '0;
                strap = sb;
                repeat (2) @(negedge clk);
                chk(pwm == '0, "R1", "outputs while disabled", int'(pwm), 0);

                // detection window
                clear_stats();
                mon_on = 1'b1;
                en     = 1'b1;
                run_ticks(DET, p);
                total = 0;
                for (int i = 0; i < NPH; i++) total += highs[i];
                chk(total == 0, "R2", "high cycles in window", total, 0);

                // free run, no termination: every start after the first is a restart
                clear_stats();
                run_ticks(NTICK, p);
                @(negedge clk);
                for (int i = 0; i < NPH; i++) begin
                    int exp;
                    exp = mask[i] ? NTICK / n : 0;
                    chk(rises[i] == exp, mask[i] ? "R3 R9" : "R3 R4",
                        $sformatf("rises phase %0d strap %0d pace %0d", i + 1, s, p),
                        rises[i], exp);
                end
                chk(order[0] == 0, "R1", "first start after enable", order[0], 0);
                for (int k = 0; k < 2 * n; k++) begin
                    chk(order[k] == alist[k % n], "R5",
                        $sformatf("start order slot %0d strap %0d", k, s),
                        order[k], alist[k % n]);
                end
                chk(max_on >= 2, "R10", "overlapping outputs", max_on, 2);

                // termination held on every phase, including grounded ones
                term = '1;
                repeat (3) @(negedge clk);
                clear_stats();
                run_ticks(NTICK, p);
                @(negedge clk);
                for (int i = 0; i < NPH; i++) begin
                    int exp;
                    exp = mask[i] ? NTICK / n : 0;
                    chk(rises[i] == exp, mask[i] ? "R6" : "R4",
                        $sformatf("starts phase %0d strap %0d pace %0d", i + 1, s, p),
                        rises[i], exp);
                    chk(highs[i] == exp, mask[i] ? "R7 R8" : "R4",
                        $sformatf("high cycles phase %0d strap %0d pace %0d", i + 1, s, p),
                        highs[i], exp);
                end
                mon_on = 1'b0;
            end
        end

        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(pwm == '0, "R1", "outputs after final disable", int'(pwm), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule